// File: doc/BRIEF.md
# DDR2 Command Decoder and Power-State Tracker

This block sits beside a DDR2 memory controller and observes the control pins it drives to the memory: chip select, the row and column strobes, write enable, clock enable, the bank select bits and address bit 10. On every rising clock edge it samples them and combines them with the clock-enable value it kept from the edge before. From this it names the command on the bus with a one-hot code. The same pin pattern can therefore mean a normal command, entry into a low-power mode, or a wake-up.

Besides the command code, the block reports the bank the command addresses and the auto-precharge / all-banks flag. It follows the memory's power state (active, power-down or self-refresh) and keeps a sticky error flag. The flag is set by any pin pattern that is not a defined command and by a read or write that would cut short a 4-beat burst. Only the reinitialise input clears the flag. All outputs are registered and show the result one clock after the edge on which the pins were sampled.

Top module: `ddr2_cmd_watch`

## Requirements
- R1: When `rst_n` is low at a clock edge, the block clears `cmd_oh`, `cmd_bank`, `cmd_ap` and `illegal`, sets `pwr_state` to 0 (active) and sets the stored clock-enable sample to low. As a result, the first edge after reset that sees `clk_en` high decodes as wake-up (`cmd_oh` bit 6).
- R2: With `clk_en` high on both the previous and the current edge, the block decodes as follows. `sel_n` high gives Deselect (bit 0). `sel_n` low with row strobe, column strobe and write enable all high gives No-Operation (bit 1). All four low gives Mode Register Set (bit 2), and `cmd_bank` shows `bank_sel`. Row strobe low with column strobe and write enable high gives Bank Activate (bit 10), with `cmd_bank` equal to `bank_sel`. At most one bit of `cmd_oh` is ever set.
- R3: With `sel_n`, row strobe and column strobe low and write enable high, the result depends on clock enable. If clock enable stays high, the result is Auto-Refresh (bit 3). If clock enable goes from high to low, the result is Self-Refresh Entry (bit 4), and `pwr_state` becomes 2.
- R4: When clock enable goes from high to low with a Deselect or No-Operation pattern, the result is Power-Down Entry (bit 5), and `pwr_state` becomes 1.
- R5: A low-to-high clock-enable step gives wake-up (bit 6) whatever the other pins hold, and `pwr_state` returns to 0. A low-to-low step gives a hold cycle (bit 7), and `pwr_state` is unchanged.
- R6: Row strobe low, column strobe high and write enable low gives a precharge. With `addr_ap` low it is a single-bank precharge (bit 8), and `cmd_bank` equals `bank_sel`. With `addr_ap` high it is precharge-all (bit 9), with `cmd_ap` high and `cmd_bank` 0.
- R7: Row strobe high and column strobe low gives a column access: Write when write enable is low, Read when it is high. With `addr_ap` low the codes are Write (bit 11) and Read (bit 13). With `addr_ap` high they are Write with auto-precharge (bit 12) and Read with auto-precharge (bit 14), with `cmd_ap` high. `cmd_bank` equals `bank_sel` in all four cases.
- R8: An undefined pattern gives the error code (bit 15) and sets `illegal`, and `pwr_state` is unchanged. The undefined patterns are: row and column strobes high with write enable low and `sel_n` low, under a steady-high clock enable; and any pattern on a high-to-low clock-enable step other than those of R3 and R4.
- R9: `illegal` stays set until an edge with `reinit` high and no new error. An error on the same edge as `reinit` wins, and the flag stays set.
- R10: When `bl4_mode` is high, a Read or Write accepted on one edge blocks a Read or Write on the very next edge. That next access decodes as the error code (bit 15) and sets `illegal`. An access two edges later is accepted. When `bl4_mode` is low, back-to-back accesses are accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reinit | input | 1 | Clears the sticky error flag |
| bl4_mode | input | 1 | High: bursts are 4 beats and may not be cut short |
| clk_en | input | 1 | Observed memory clock enable |
| sel_n | input | 1 | Observed chip select, active low |
| row_strb_n | input | 1 | Observed row address strobe, active low |
| col_strb_n | input | 1 | Observed column address strobe, active low |
| wr_en_n | input | 1 | Observed write enable, active low |
| addr_ap | input | 1 | Observed address bit 10 |
| bank_sel | input | BA_W | Observed bank address |
| cmd_oh | output | 16 | One-hot command code, bit positions as in R2 to R10 |
| cmd_bank | output | BA_W | Bank of the decoded command, 0 when none applies |
| cmd_ap | output | 1 | Auto-precharge or all-banks indication |
| pwr_state | output | 2 | 0 active, 1 power-down, 2 self-refresh |
| illegal | output | 1 | Sticky error flag |

## Verification
The main decoder is driven through every row of the defined command set under a steady-high clock enable. Each precharge and column-access pattern is given once with address bit 10 low and once with it high, which shows that the flag picks the variant and that the bank is passed or suppressed correctly. The refresh pattern is given under steady and falling clock enable, and the idle patterns under steady and falling clock enable, which separates refresh from self-refresh entry and no-op from power-down entry. Wake-up edges carry deliberately unusual pin values to show those pins are ignored. Burst interruption is tried at a one-cycle and a two-cycle spacing with 4-beat bursts, and back-to-back with 8-beat bursts. Reinitialise is tried both alone and together with a fresh error.

// File: rtl/ddr2_cmd_watch.sv
module ddr2_cmd_watch #(
  parameter int BA_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reinit,
  input  logic            bl4_mode,
  input  logic            clk_en,
  input  logic            sel_n,
  input  logic            row_strb_n,
  input  logic            col_strb_n,
  input  logic            wr_en_n,
  input  logic            addr_ap,
  input  logic [BA_W-1:0] bank_sel,
  output logic [15:0]     cmd_oh,
  output logic [BA_W-1:0] cmd_bank,
  output logic            cmd_ap,
  output logic [1:0]      pwr_state,
  output logic            illegal
);
  localparam int C_DES = 0, C_NOP = 1, C_MRS = 2, C_REF = 3;
  localparam int C_SRE = 4, C_PDE = 5, C_WAKE = 6, C_HOLD = 7;
  localparam int C_PRE = 8, C_PREA = 9, C_ACT = 10, C_WR = 11;
  localparam int C_WRA = 12, C_RD = 13, C_RDA = 14, C_BAD = 15;
  localparam int CMD_N = 16;
  localparam logic [1:0] P_ACT = 2'd0, P_PDN = 2'd1, P_SRF = 2'd2;

  logic             cke_q;
  logic             burst_busy;
  logic [CMD_N-1:0] dec;
  logic [2:0]       rcw;
  logic             dec_rw, use_bank, use_ap;

  assign rcw = {row_strb_n, col_strb_n, wr_en_n};

  always_comb begin
    dec = '0;
    case ({cke_q, clk_en})
      2'b11: begin
        if (sel_n) dec[C_DES] = 1'b1;
        else begin
          case (rcw)
            3'b111:  dec[C_NOP] = 1'b1;
            3'b000:  dec[C_MRS] = 1'b1;
            3'b001:  dec[C_REF] = 1'b1;
            3'b010:  dec[addr_ap ? C_PREA : C_PRE] = 1'b1;
            3'b011:  dec[C_ACT] = 1'b1;
            3'b100:  dec[addr_ap ? C_WRA : C_WR] = 1'b1;
            3'b101:  dec[addr_ap ? C_RDA : C_RD] = 1'b1;
            default: dec[C_BAD] = 1'b1;
          endcase
          if (burst_busy && (rcw[2:1] == 2'b10)) begin
            dec = '0;
            dec[C_BAD] = 1'b1;
          end
        end
      end
      2'b10: begin
        if (sel_n || rcw == 3'b111) dec[C_PDE] = 1'b1;
        else if (rcw == 3'b001)     dec[C_SRE] = 1'b1;
        else                        dec[C_BAD] = 1'b1;
      end
      2'b01:   dec[C_WAKE] = 1'b1;
      default: dec[C_HOLD] = 1'b1;
    endcase
  end

  assign dec_rw   = |dec[C_RDA:C_WR];
  assign use_bank = dec_rw | dec[C_MRS] | dec[C_PRE] | dec[C_ACT];
  assign use_ap   = dec[C_PREA] | dec[C_WRA] | dec[C_RDA];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q      <= 1'b0;
      burst_busy <= 1'b0;
      cmd_oh     <= '0;
      cmd_bank   <= '0;
      cmd_ap     <= 1'b0;
      pwr_state  <= P_ACT;
      illegal    <= 1'b0;
    end else begin
      cke_q      <= clk_en;
      burst_busy <= bl4_mode & dec_rw;
      cmd_oh     <= dec;
      cmd_bank   <= use_bank ? bank_sel : '0;
      cmd_ap     <= use_ap;
      if (dec[C_SRE])       pwr_state <= P_SRF;
      else if (dec[C_PDE])  pwr_state <= P_PDN;
      else if (dec[C_WAKE]) pwr_state <= P_ACT;
      if (dec[C_BAD])       illegal <= 1'b1;
      else if (reinit)      illegal <= 1'b0;
    end
  end
endmodule

// File: rtl/ddr2_cmd_watch_chk.sv
module ddr2_cmd_watch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reinit,
  input logic        bl4_mode,
  input logic [15:0] cmd_oh,
  input logic [1:0]  pwr_state,
  input logic        illegal
);
  logic cmd_rw;
  assign cmd_rw = |cmd_oh[14:11];

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_oh));
  a_r3_sref_state: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oh[4] |-> pwr_state == 2'd2);
  a_r4_pdn_state: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oh[5] |-> pwr_state == 2'd1);
  a_r5_wake_active: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oh[6] |-> pwr_state == 2'd0);
  a_r8_bad_flags: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oh[15] |-> illegal);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && !reinit) |=> illegal);
  a_r10_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rw && $past(bl4_mode)) |=> !cmd_rw);
endmodule

bind ddr2_cmd_watch ddr2_cmd_watch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reinit(reinit), .bl4_mode(bl4_mode),
  .cmd_oh(cmd_oh), .pwr_state(pwr_state), .illegal(illegal)
);

// File: tb/test_ddr2_cmd_watch.sv
`timescale 1ns/1ps
module test_ddr2_cmd_watch;
  logic clk = 1'b0;
  logic rst_n, reinit, bl4_mode, clk_en, sel_n, row_strb_n, col_strb_n, wr_en_n, addr_ap;
  logic [1:0] bank_sel, cmd_bank, pwr_state;
  logic [15:0] cmd_oh;
  logic cmd_ap, illegal;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ddr2_cmd_watch #(.BA_W(2)) i_ddr2_cmd_watch (
    .clk(clk), .rst_n(rst_n), .reinit(reinit), .bl4_mode(bl4_mode),
    .clk_en(clk_en), .sel_n(sel_n), .row_strb_n(row_strb_n), .col_strb_n(col_strb_n),
    .wr_en_n(wr_en_n), .addr_ap(addr_ap), .bank_sel(bank_sel),
    .cmd_oh(cmd_oh), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap),
    .pwr_state(pwr_state), .illegal(illegal));

  // {req, cke, sel/row/col/we, a10, bank, bl4, exp cmd bit, exp bank, exp ap, exp pwr, exp illegal, pad}
  // cmd bits: 0 DES 1 NOP 2 MRS 3 REF 4 SRE 5 PDE 6 WAKE 7 HOLD 8 PRE 9 PREA 10 ACT 11 WR 12 WRA 13 RD 14 RDA 15 BAD
  localparam int NV = 31;
  localparam logic [23:0] VEC [NV] = '{
    {4'd5, 1'b1,4'b1111,1'b0,2'd0,1'b0, 4'd6, 2'd0,1'b0,2'd0,1'b0,1'b0}, // R5 first wake after reset
    {4'd2, 1'b1,4'b1111,1'b0,2'd0,1'b0, 4'd0, 2'd0,1'b0,2'd0,1'b0,1'b0}, // R2 deselect
    {4'd2, 1'b1,4'b0111,1'b0,2'd0,1'b0, 4'd1, 2'd0,1'b0,2'd0,1'b0,1'b0}, // R2 nop
    {4'd2, 1'b1,4'b0000,1'b0,2'd3,1'b0, 4'd2, 2'd3,1'b0,2'd0,1'b0,1'b0}, // R2 mode reg
    {4'd2, 1'b1,4'b0011,1'b0,2'd1,1'b0, 4'd10,2'd1,1'b0,2'd0,1'b0,1'b0}, // R2 activate
    {4'd6, 1'b1,4'b0010,1'b0,2'd2,1'b0, 4'd8, 2'd2,1'b0,2'd0,1'b0,1'b0}, // R6 single
    {4'd6, 1'b1,4'b0010,1'b1,2'd2,1'b0, 4'd9, 2'd0,1'b1,2'd0,1'b0,1'b0}, // R6 all
    {4'd7, 1'b1,4'b0100,1'b0,2'd1,1'b0, 4'd11,2'd1,1'b0,2'd0,1'b0,1'b0}, // R7 write
    {4'd7, 1'b1,4'b0101,1'b1,2'd3,1'b0, 4'd14,2'd3,1'b1,2'd0,1'b0,1'b0}, // R7 read ap, R10 bl8 back-to-back
    {4'd7, 1'b1,4'b0101,1'b0,2'd0,1'b0, 4'd13,2'd0,1'b0,2'd0,1'b0,1'b0}, // R7 read
    {4'd7, 1'b1,4'b0100,1'b1,2'd2,1'b0, 4'd12,2'd2,1'b1,2'd0,1'b0,1'b0}, // R7 write ap
    {4'd3, 1'b1,4'b0001,1'b0,2'd0,1'b0, 4'd3, 2'd0,1'b0,2'd0,1'b0,1'b0}, // R3 refresh
    {4'd3, 1'b0,4'b0001,1'b0,2'd0,1'b0, 4'd4, 2'd0,1'b0,2'd2,1'b0,1'b0}, // R3 self-refresh entry
    {4'd5, 1'b0,4'b0000,1'b1,2'd3,1'b0, 4'd7, 2'd0,1'b0,2'd2,1'b0,1'b0}, // R5 hold
    {4'd5, 1'b1,4'b0000,1'b1,2'd3,1'b0, 4'd6, 2'd0,1'b0,2'd0,1'b0,1'b0}, // R5 wake, pins ignored
    {4'd4, 1'b1,4'b0111,1'b0,2'd0,1'b0, 4'd1, 2'd0,1'b0,2'd0,1'b0,1'b0}, // R4 nop
    {4'd4, 1'b0,4'b0111,1'b0,2'd0,1'b0, 4'd5, 2'd0,1'b0,2'd1,1'b0,1'b0}, // R4 pd entry via nop
    {4'd5, 1'b0,4'b1111,1'b0,2'd0,1'b0, 4'd7, 2'd0,1'b0,2'd1,1'b0,1'b0}, // R5 hold in pd
    {4'd5, 1'b1,4'b0110,1'b0,2'd0,1'b0, 4'd6, 2'd0,1'b0,2'd0,1'b0,1'b0}, // R5 wake
    {4'd4, 1'b1,4'b1111,1'b0,2'd0,1'b0, 4'd0, 2'd0,1'b0,2'd0,1'b0,1'b0}, // R4 deselect
    {4'd4, 1'b0,4'b1000,1'b0,2'd0,1'b0, 4'd5, 2'd0,1'b0,2'd1,1'b0,1'b0}, // R4 pd entry via deselect
    {4'd5, 1'b1,4'b1111,1'b0,2'd0,1'b0, 4'd6, 2'd0,1'b0,2'd0,1'b0,1'b0}, // R5 wake
    {4'd10,1'b1,4'b0101,1'b0,2'd1,1'b1, 4'd13,2'd1,1'b0,2'd0,1'b0,1'b0}, // R10 read bl4
    {4'd10,1'b1,4'b0100,1'b0,2'd1,1'b1, 4'd15,2'd0,1'b0,2'd0,1'b1,1'b0}, // R10 cut short
    {4'd10,1'b1,4'b0111,1'b0,2'd0,1'b1, 4'd1, 2'd0,1'b0,2'd0,1'b1,1'b0}, // R10 nop
    {4'd10,1'b1,4'b0100,1'b1,2'd2,1'b1, 4'd12,2'd2,1'b1,2'd0,1'b1,1'b0}, // R10 accepted
    {4'd10,1'b1,4'b0111,1'b0,2'd0,1'b1, 4'd1, 2'd0,1'b0,2'd0,1'b1,1'b0}, // R10 nop
    {4'd10,1'b1,4'b0101,1'b0,2'd0,1'b1, 4'd13,2'd0,1'b0,2'd0,1'b1,1'b0}, // R10 two apart ok
    {4'd8, 1'b1,4'b0110,1'b0,2'd0,1'b0, 4'd15,2'd0,1'b0,2'd0,1'b1,1'b0}, // R8 undefined code
    {4'd8, 1'b0,4'b0011,1'b0,2'd0,1'b0, 4'd15,2'd0,1'b0,2'd0,1'b1,1'b0}, // R8 bad on falling cke
    {4'd5, 1'b1,4'b1111,1'b0,2'd0,1'b0, 4'd6, 2'd0,1'b0,2'd0,1'b1,1'b0}  // R5 wake
  };

  task automatic drive(input logic ck, input logic [3:0] srcw, input logic ap,
                       input logic [1:0] ba, input logic bl4);
    clk_en = ck; {sel_n, row_strb_n, col_strb_n, wr_en_n} = srcw;
    addr_ap = ap; bank_sel = ba; bl4_mode = bl4;
  endtask

  task automatic check(input string tag, input int bitn, input logic [1:0] bk,
                       input logic ap, input logic [1:0] pw, input logic il);
    logic [15:0] exp_oh;
    exp_oh = (bitn < 0) ? 16'h0 : (16'h1 << bitn);
    n_run++;
    if (cmd_oh !== exp_oh || cmd_bank !== bk || cmd_ap !== ap ||
        pwr_state !== pw || illegal !== il) begin
      n_fail++;
      $display("FAIL %s: got oh=%h bank=%0d ap=%0b pwr=%0d ill=%0b, expected oh=%h bank=%0d ap=%0b pwr=%0d ill=%0b",
               tag, cmd_oh, cmd_bank, cmd_ap, pwr_state, illegal, exp_oh, bk, ap, pw, il);
    end
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; reinit = 1'b0;
    drive(1'b1, 4'b0110, 1'b1, 2'd3, 1'b0);
    step; step;
    check("R1 reset", -1, 2'd0, 1'b0, 2'd0, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][19], VEC[i][18:15], VEC[i][14], VEC[i][13:12], VEC[i][11]);
      step;
      check($sformatf("R%0d vec%0d", VEC[i][23:20], i), int'(VEC[i][10:7]),
            VEC[i][6:5], VEC[i][4], VEC[i][3:2], VEC[i][1]);
    end
    // R9: reinit clears, then stays clear
    drive(1'b1, 4'b0111, 1'b0, 2'd0, 1'b0); reinit = 1'b1; step;
    check("R9 reinit clears", 1, 2'd0, 1'b0, 2'd0, 1'b0);
    reinit = 1'b0; step;
    check("R9 stays clear", 1, 2'd0, 1'b0, 2'd0, 1'b0);
    // R8: fresh error after clearing
    drive(1'b1, 4'b0110, 1'b0, 2'd0, 1'b0); step;
    check("R8 sets flag", 15, 2'd0, 1'b0, 2'd0, 1'b1);
    drive(1'b1, 4'b0111, 1'b0, 2'd0, 1'b0); step; step;
    check("R9 sticky", 1, 2'd0, 1'b0, 2'd0, 1'b1);
    // R9: error together with reinit keeps flag
    drive(1'b1, 4'b0110, 1'b0, 2'd0, 1'b0); reinit = 1'b1; step;
    check("R9 error beats reinit", 15, 2'd0, 1'b0, 2'd0, 1'b1);
    drive(1'b1, 4'b0111, 1'b0, 2'd0, 1'b0); step;
    check("R9 reinit after", 1, 2'd0, 1'b0, 2'd0, 1'b0);
    reinit = 1'b0;
    // R1: reset out of power-down
    drive(1'b0, 4'b0111, 1'b0, 2'd0, 1'b0); step;
    check("R4 pd entry", 5, 2'd0, 1'b0, 2'd1, 1'b0);
    drive(1'b1, 4'b0111, 1'b0, 2'd0, 1'b0); rst_n = 1'b0; step;
    check("R1 reset from pd", -1, 2'd0, 1'b0, 2'd0, 1'b0);
    rst_n = 1'b1; step;
    check("R1 stored cke low", 6, 2'd0, 1'b0, 2'd0, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule